// File: doc/BRIEF.md
# TDM D-Channel Byte Exchange and Interrupt Controller

This block sits on a 2.048 Mb/s time-division serial link whose frame holds 32 eight-bit channels. It sends and receives D-channel signalling bits in a fixed timeslot of that frame. Over a group of frames it gathers one full byte in each direction. A microprocessor reads the received byte and writes the next byte to send through one register at address 0x04 on a simple strobe bus.

A single interrupt line tells the processor when this register may be accessed safely. The line rises once per frame group, just after the last bit of the byte has been taken in. It falls on the first processor access to address 0x04, or at the next frame pulse, whichever comes first. At that frame pulse the written byte moves into the transmit shifter. A new group then starts.

The `slow_mode` input selects between two rates. At 16 kb/s, two bits move per frame and a group is four frames long. At 8 kb/s, one bit moves per frame and a group is eight frames long. `frame_n` is sampled low during the last bit cell of a frame, and the cell after it is cell 0 of the next frame.

Top module: `tdm_dch_ctrl`

## Requirements
- R1: After reset the interrupt is low and `tx_oe` is low. A read of address 0x04 returns 0x00. The transmit byte is all ones, and the frame index is 0 at the first frame pulse.
- R2: With `slow_mode`=0, the D-channel occupies cells 0 and 1 of channel 0. `tx_oe` is high for exactly those two cells of every frame, and a group is four frames.
- R3: With `slow_mode`=1, one D-channel bit is moved per frame, in cell 0 of channel 0. `tx_oe` is high for one cell per frame, and a group is eight frames.
- R4: The transmit byte is sent MSB first. It is copied from the write register at the frame pulse that starts a group: the first pulse after reset, or the pulse that ends the last frame of a group. A write during a group does not change the bits being sent in that group.
- R5: Received bits are shifted in MSB first. The read register changes only when the last bit of a group arrives. A read of 0x04 returns the byte from the most recently completed group.
- R6: With `slow_mode`=0, the interrupt is low in bit cell 1 and high in bit cell 2 of the fourth frame of every group. It stays low in the other frames of the group.
- R7: With `slow_mode`=1, the interrupt is low in bit cell 0 and high in bit cell 1 of the eighth frame of every group.
- R8: A read or a write of address 0x04 while the interrupt is high makes it low from the next bit cell on.
- R9: If no access comes first, the interrupt falls at the next frame pulse, so it is low in cell 0 of the following frame.
- R10: A read or write at any other address leaves the interrupt unchanged, returns 0x00 on `bus_rdata` and does not change the next transmitted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one cycle per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_mode | input | 1 | 1 selects 8 kb/s, 0 selects 16 kb/s |
| frame_n | input | 1 | Active-low frame pulse, low in the last cell of a frame |
| rx_data | input | 1 | Serial receive data |
| bus_addr | input | 8 | Microport address |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0x00 unless 0x04 is read |
| tx_data | output | 1 | Serial transmit data, 0 while not enabled |
| tx_oe | output | 1 | Output enable for the transmit timeslot |
| irq | output | 1 | Access-window interrupt, active high |

## Verification
Some rules are checked by the assertions on every cycle. The interrupt must rise after each completed byte and only then. It must fall after a matching access or after a frame pulse. The read register must hold between group ends, and the transmit shifter must take the write register at each group swap. Other behaviour shows only in the bench scenarios. These include the exact bit cell of the rising edge at each rate, the group length of four or eight frames, and MSB-first ordering in both directions. They also include the rule that a write during a group waits for the next group, and that other addresses are ignored.

// File: rtl/tdm_dch_pkg.sv
package tdm_dch_pkg;
  localparam int unsigned DCH_W = 8;
  typedef logic [DCH_W-1:0] dch_byte_t;
endpackage

// File: rtl/dch_frame_timer.sv
module dch_frame_timer #(
  parameter int unsigned BITS_PER_FRAME = 256,
  parameter int unsigned DCH_SLOT       = 0,
  parameter int unsigned FAST_GROUP     = 4,
  parameter int unsigned SLOW_GROUP     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_mode,
  input  logic frame_n,
  output logic pulse,
  output logic swap_en,
  output logic dbit_en,
  output logic byte_done
);
  localparam int unsigned CNT_W = $clog2(BITS_PER_FRAME);
  localparam int unsigned FRM_W = $clog2(SLOW_GROUP);
  localparam logic [CNT_W-1:0] D_FIRST   = CNT_W'(DCH_SLOT * 8);
  localparam logic [CNT_W-1:0] D_SECOND  = CNT_W'(DCH_SLOT * 8 + 1);
  localparam logic [CNT_W-1:0] LAST_CELL = CNT_W'(BITS_PER_FRAME - 1);
  localparam logic [FRM_W-1:0] FAST_LAST = FRM_W'(FAST_GROUP - 1);
  localparam logic [FRM_W-1:0] SLOW_LAST = FRM_W'(SLOW_GROUP - 1);

  logic [CNT_W-1:0] bit_cnt, bit_cnt_n;
  logic [FRM_W-1:0] frm_cnt, frm_cnt_n;
  logic             synced, synced_n;
  logic             grp_end;
  logic             last_dbit;

  assign pulse     = ~frame_n;
  assign grp_end   = frm_cnt >= (slow_mode ? SLOW_LAST : FAST_LAST);
  assign swap_en   = pulse & (~synced | grp_end);
  assign dbit_en   = synced & ((bit_cnt == D_FIRST) | (~slow_mode & (bit_cnt == D_SECOND)));
  assign last_dbit = synced & (bit_cnt == (slow_mode ? D_FIRST : D_SECOND));
  assign byte_done = last_dbit & grp_end;

  always_comb begin
    bit_cnt_n = bit_cnt;
    frm_cnt_n = frm_cnt;
    synced_n  = synced;
    if (pulse) begin
      bit_cnt_n = '0;
      frm_cnt_n = (~synced | grp_end) ? '0 : frm_cnt + FRM_W'(1);
      synced_n  = 1'b1;
    end else if (synced) begin
      bit_cnt_n = (bit_cnt == LAST_CELL) ? '0 : bit_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      frm_cnt <= '0;
      synced  <= 1'b0;
    end else begin
      bit_cnt <= bit_cnt_n;
      frm_cnt <= frm_cnt_n;
      synced  <= synced_n;
    end
  end

  // R2: a frame pulse always restarts the frame at cell 0
  assert_pulse_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (bit_cnt == '0) && synced);
  // R5: a byte completes only in a D-channel bit cell
  assert_done_in_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> dbit_en);
endmodule

// File: rtl/dch_serial_port.sv
module dch_serial_port
  import tdm_dch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dbit_en,
  input  logic      byte_done,
  input  logic      swap_en,
  input  logic      rx_bit,
  input  logic      wr_hit,
  input  dch_byte_t wdata,
  output logic      tx_bit,
  output dch_byte_t rd_byte
);
  dch_byte_t tx_hold, tx_hold_n;
  dch_byte_t tx_shift, tx_shift_n;
  dch_byte_t shadow, shadow_n;
  dch_byte_t rd_reg, rd_reg_n;
  dch_byte_t rx_next;

  assign rx_next = {shadow[DCH_W-2:0], rx_bit};
  assign tx_bit  = tx_shift[DCH_W-1];
  assign rd_byte = rd_reg;

  always_comb begin
    tx_hold_n  = wr_hit ? wdata : tx_hold;
    tx_shift_n = tx_shift;
    if (swap_en)      tx_shift_n = tx_hold;
    else if (dbit_en) tx_shift_n = {tx_shift[DCH_W-2:0], 1'b1};
    shadow_n   = dbit_en ? rx_next : shadow;
    rd_reg_n   = byte_done ? rx_next : rd_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold  <= '1;
      tx_shift <= '1;
      shadow   <= '0;
      rd_reg   <= '0;
    end else begin
      tx_hold  <= tx_hold_n;
      tx_shift <= tx_shift_n;
      shadow   <= shadow_n;
      rd_reg   <= rd_reg_n;
    end
  end

  // R4: the group swap loads the byte the processor left in the write register
  assert_swap_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_en && !dbit_en) |=> tx_shift == $past(tx_hold));
  // R5: the read register holds between byte completions
  assert_rd_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rd_reg));
endmodule

// File: rtl/dch_irq_ctrl.sv
module dch_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic byte_done,
  input  logic acc_hit,
  input  logic pulse,
  output logic irq
);
  logic irq_q, irq_n;

  always_comb begin
    irq_n = irq_q;
    if (byte_done)             irq_n = 1'b1;
    else if (acc_hit || pulse) irq_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_n;
  end

  assign irq = irq_q;

  // R6: a completed byte raises the line in the following cell
  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> irq_q);
  // R7: the line never rises without a completed byte
  assert_irq_rise_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(byte_done));
  // R8: an access to the register drops the line
  assert_irq_clr_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && !byte_done) |=> !irq_q);
  // R9: a frame pulse drops the line
  assert_irq_clr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !byte_done) |=> !irq_q);
endmodule

// File: rtl/tdm_dch_ctrl.sv
module tdm_dch_ctrl
  import tdm_dch_pkg::*;
#(
  parameter int unsigned BITS_PER_FRAME = 256,
  parameter int unsigned DCH_SLOT       = 0,
  parameter int unsigned FAST_GROUP     = 4,
  parameter int unsigned SLOW_GROUP     = 8,
  parameter int unsigned ADDR_W         = 8,
  parameter logic [ADDR_W-1:0] DCH_ADDR = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_mode,
  input  logic              frame_n,
  input  logic              rx_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DCH_W-1:0]  bus_wdata,
  output logic [DCH_W-1:0]  bus_rdata,
  output logic              tx_data,
  output logic              tx_oe,
  output logic              irq
);
  logic [1:0] rst_pipe;
  logic       core_rst_n;
  logic       addr_hit, acc_hit, wr_hit;
  logic       pulse, swap_en, dbit_en, byte_done, tx_bit;
  dch_byte_t  rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  assign addr_hit  = (bus_addr == DCH_ADDR);
  assign acc_hit   = addr_hit & (bus_rd | bus_wr);
  assign wr_hit    = addr_hit & bus_wr;
  assign bus_rdata = (addr_hit & bus_rd) ? rd_byte : '0;
  assign tx_oe     = dbit_en;
  assign tx_data   = dbit_en & tx_bit;

  dch_frame_timer #(
    .BITS_PER_FRAME(BITS_PER_FRAME),
    .DCH_SLOT      (DCH_SLOT),
    .FAST_GROUP    (FAST_GROUP),
    .SLOW_GROUP    (SLOW_GROUP)
  ) i_timer (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .slow_mode(slow_mode),
    .frame_n  (frame_n),
    .pulse    (pulse),
    .swap_en  (swap_en),
    .dbit_en  (dbit_en),
    .byte_done(byte_done)
  );

  dch_serial_port i_port (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .dbit_en  (dbit_en),
    .byte_done(byte_done),
    .swap_en  (swap_en),
    .rx_bit   (rx_data),
    .wr_hit   (wr_hit),
    .wdata    (bus_wdata),
    .tx_bit   (tx_bit),
    .rd_byte  (rd_byte)
  );

  dch_irq_ctrl i_irq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .byte_done(byte_done),
    .acc_hit  (acc_hit),
    .pulse    (pulse),
    .irq      (irq)
  );

  // R1: the enable stays low until the first frame pulse has been seen
  assert_no_oe_before_sync_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($past(core_rst_n) && !$past(core_rst_n, 2)) |-> !tx_oe);
endmodule

// File: tb/test_tdm_dch_ctrl.sv
module test_tdm_dch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, slow_mode, frame_n, rx_data;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_rd, bus_wr, tx_data, tx_oe, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [255:0] irq_v;
  logic [7:0]   tx_acc, rx_src, got_rdata;
  int           oe_cnt;

  always #4 clk = ~clk;

  tdm_dch_ctrl i_tdm_dch_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .frame_n(frame_n),
    .rx_data(rx_data), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
    .tx_oe(tx_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic slow);
    rst_n = 1'b0; slow_mode = slow; frame_n = 1'b1; rx_data = 1'b0;
    bus_addr = 8'h00; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [7:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 got_rdata = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic sync_frame();
    @(negedge clk); frame_n = 1'b0;
  endtask

  // One full frame; one optional bus access in cell acc_cell
  task automatic run_frame(input int acc_cell, input logic [7:0] a,
                           input logic rd, input logic wr, input logic [7:0] wd);
    oe_cnt = 0;
    for (int c = 0; c < 256; c++) begin
      @(negedge clk);
      irq_v[c] = irq;
      if (tx_oe) begin
        tx_acc = {tx_acc[6:0], tx_data};
        oe_cnt++;
      end
      frame_n = (c == 255) ? 1'b0 : 1'b1;
      if (c == 0 || (!slow_mode && c == 1)) begin
        rx_data = rx_src[7];
        rx_src  = {rx_src[6:0], 1'b0};
      end else begin
        rx_data = 1'b0;
      end
      if (c == acc_cell) begin
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        #1 got_rdata = bus_rdata;
      end else begin
        bus_rd = 1'b0; bus_wr = 1'b0;
      end
    end
  endtask

  task automatic idle_frame();
    run_frame(-1, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check("R1 irq after reset", irq, 1'b0);
    check("R1 tx_oe after reset", tx_oe, 1'b0);
    cpu_read(8'h04);
    check("R1 read register after reset", got_rdata, 8'h00);
    sync_frame();
    rx_src = 8'h00; tx_acc = 8'h00;
    idle_frame();
    check("R1 transmit bits all ones", tx_acc[1:0], 2'b11);
    check("R2 two enabled cells per frame", oe_cnt, 2);
    check("R6 no irq in first frame", irq_v == '0, 1'b1);
  endtask

  task automatic t_normal_group();
    do_reset(1'b0);
    cpu_write(8'h04, 8'hA5);
    sync_frame();
    rx_src = 8'h3C; tx_acc = 8'h00;
    idle_frame();
    check("R6 frame0 no irq", irq_v == '0, 1'b1);
    check("R2 frame0 enabled cells", oe_cnt, 2);
    run_frame(40, 8'h04, 1'b0, 1'b1, 8'h5A);
    check("R6 frame1 no irq", irq_v == '0, 1'b1);
    idle_frame();
    check("R6 frame2 no irq", irq_v == '0, 1'b1);
    run_frame(10, 8'h04, 1'b1, 1'b0, 8'h00);
    check("R6 irq low in cell 1", irq_v[1], 1'b0);
    check("R6 irq high in cell 2", irq_v[2], 1'b1);
    check("R8 irq high before read", irq_v[10], 1'b1);
    check("R8 irq low after read", irq_v[11], 1'b0);
    check("R5 received byte", got_rdata, 8'h3C);
    check("R4 transmitted byte MSB first", tx_acc, 8'hA5);
  endtask

  task automatic t_write_clear();
    rx_src = 8'h69; tx_acc = 8'h00;
    idle_frame();
    run_frame(9, 8'h04, 1'b1, 1'b0, 8'h00);
    check("R5 read register held mid-group", got_rdata, 8'h3C);
    run_frame(100, 8'h04, 1'b0, 1'b1, 8'h96);
    run_frame(50, 8'h04, 1'b0, 1'b1, 8'h96);
    check("R8 irq high before write", irq_v[49], 1'b1);
    check("R8 irq low after write", irq_v[51], 1'b0);
    check("R4 mid-group write waits for next group", tx_acc, 8'h5A);
  endtask

  task automatic t_pulse_clear();
    rx_src = 8'hF0; tx_acc = 8'h00;
    run_frame(3, 8'h04, 1'b1, 1'b0, 8'h00);
    check("R5 byte of completed group", got_rdata, 8'h69);
    idle_frame();
    run_frame(60, 8'h05, 1'b0, 1'b1, 8'h00);
    run_frame(30, 8'h05, 1'b1, 1'b0, 8'h00);
    check("R10 other address reads zero", got_rdata, 8'h00);
    check("R10 other address keeps irq", irq_v[31], 1'b1);
    check("R9 irq held to frame end", irq_v[255], 1'b1);
    check("R4 transmitted byte", tx_acc, 8'h96);
    tx_acc = 8'h00;
    run_frame(5, 8'h04, 1'b1, 1'b0, 8'h00);
    check("R9 irq cleared by frame pulse", irq_v[0], 1'b0);
    check("R10 other-address write ignored", tx_acc[1:0], 2'b10);
    check("R5 byte after pulse clear", got_rdata, 8'hF0);
  endtask

  task automatic t_slow_group();
    do_reset(1'b1);
    cpu_write(8'h04, 8'hC3);
    sync_frame();
    rx_src = 8'h81; tx_acc = 8'h00;
    for (int f = 0; f < 7; f++) begin
      idle_frame();
      check("R7 no irq before eighth frame", irq_v == '0, 1'b1);
      check("R3 one enabled cell per frame", oe_cnt, 1);
    end
    idle_frame();
    check("R7 irq low in cell 0", irq_v[0], 1'b0);
    check("R7 irq high in cell 1", irq_v[1], 1'b1);
    check("R3 transmitted byte over eight frames", tx_acc, 8'hC3);
    run_frame(2, 8'h04, 1'b1, 1'b0, 8'h00);
    check("R3 received byte over eight frames", got_rdata, 8'h81);
    check("R9 slow irq cleared by pulse", irq_v[0], 1'b0);
  endtask

  initial begin
    t_reset();
    t_normal_group();
    t_write_clear();
    t_pulse_clear();
    t_slow_group();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule